// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous request port and an external 64K x 16 static RAM whose interface has no clock. Each accepted request becomes one complete memory cycle: the address, the active-low chip select, the per-byte lane selects, the write strobe, the output-enable strobe and the data-bus drive enable are all timed in whole clock cycles. The cycle counts come from nanosecond limits held as parameters and rounded up against the clock period.

On the request side, `req_valid`/`req_ready` form a valid/ready pair. A request transfers on a rising edge where both are high. `req_ready` is high only while the sequencer is idle, so a master that holds `req_valid` high while the sequencer is busy just waits. The response side is a one-cycle `rsp_valid` pulse and cannot apply back-pressure. A master that issues a request must be able to take its response. For reads, `rsp_rdata` is valid in the pulse cycle.

The data pins of the memory are shared. The sequencer provides a separate output bus, a separate input bus and one drive enable, and leaves the three-state pad outside the block.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, `req_ready` is 1. Chip select, write strobe, output enable and both lane selects are high (inactive), and `mem_drive` is 0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. Its address, data and lane mask are registered on that edge. A request held while busy is taken in the first idle cycle that follows.
- R3: A write occupies one setup cycle (chip select low, write strobe high, data driven), then the write strobe low for P cycles, then one hold cycle with the write strobe high. `rsp_valid` is 1 in the hold cycle. P is the largest of ceil(T_PWE/CLK), ceil(T_SD/CLK), ceil(T_AW/CLK) and ceil(T_WC/CLK)-2, with a floor of 1. With the defaults, P = 4.
- R4: `req_be[0]` controls the low byte (data bits 7:0) through `mem_be_n[0]`. `req_be[1]` controls the high byte (bits 15:8) through `mem_be_n[1]`. A lane that is not requested keeps its select high for the whole access, so that byte of memory is left unchanged.
- R5: `mem_addr` and `mem_dout` stay constant from the setup cycle through the hold cycle. They do not change while the write strobe is low or on the cycle it rises.
- R6: A read holds chip select and output enable low, with the write strobe high and the bus released, for R cycles. R is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_DOE/CLK). With the defaults, R = 6. Data is sampled on the edge that ends the last of these cycles. In the next cycle all strobes are high, `rsp_valid` is 1, and `rsp_rdata` holds the sampled word with any unrequested lane forced to zero.
- R7: `mem_drive` is never 1 while output enable is low. After output enable rises, at least one cycle passes before the bus is driven.
- R8: The write strobe is low only while chip select is low and the bus is driven. Every write ends with the write strobe rising while chip select and the lane selects are still low.
- R9: `rsp_valid` is high for exactly one cycle per access, and never in a cycle where `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/LANE_W | Lane mask, active high, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, unrequested lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DATA_W/LANE_W | Lane selects, active low, bit 0 = low byte |
| mem_dout | output | DATA_W | Data toward the memory |
| mem_din | input | DATA_W | Data from the memory |
| mem_drive | output | 1 | Enables the pad driver for `mem_dout` |

## Verification
The one place where two functions meet in the same cycle is the end of a read while a write is already pending: output enable is released while `req_valid` is held high with write fields. The bench provokes this by raising a write request during a read and keeping it up. It then checks that `req_ready` stays low through the whole read and that the write is taken in the idle cycle after the read response. It also checks that `mem_drive` stays low in every cycle between output enable rising and the write setup. A memory model in the bench supplies garbage until R cycles of output enable have passed, and it rejects any write pulse shorter than P cycles. This makes an early sample or a short strobe visible in the returned data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RWAIT,
    ST_RCAPT
  } ctrl_state_t;

  // whole clock cycles covering a nanosecond limit, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int WR_PULSE = 4,
  parameter int RD_WAIT  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output ctrl_state_t      state,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_WAIT - 1);

  ctrl_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WSETUP;
          end else begin
            state_d  = ST_RWAIT;
            tmr_load = 1'b1;
            tmr_val  = RD_LD;
          end
        end
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = WR_LD;
      end
      ST_WPULSE: if (expired) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      ST_RWAIT: begin
        if (expired) begin
          state_d = ST_RCAPT;
          capture = 1'b1;
        end
      end
      ST_RCAPT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wdata_q[g*LANE_W +: LANE_W] <= '0;
        be_q[g]                     <= 1'b0;
      end else if (accept) begin
        wdata_q[g*LANE_W +: LANE_W] <= req_wdata[g*LANE_W +: LANE_W];
        be_q[g]                     <= req_be[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata_q[g*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        rdata_q[g*LANE_W +: LANE_W] <= be_q[g] ? mem_din[g*LANE_W +: LANE_W]
                                               : {LANE_W{1'b0}};
      end
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_AW_NS   = 40,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [DATA_W/LANE_W-1:0]   req_be,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic                       mem_ce_n,
  output logic                       mem_we_n,
  output logic                       mem_oe_n,
  output logic [DATA_W/LANE_W-1:0]   mem_be_n,
  output logic [DATA_W-1:0]          mem_dout,
  input  logic [DATA_W-1:0]          mem_din,
  output logic                       mem_drive
);

  localparam int LANES    = DATA_W / LANE_W;
  localparam int WR_PULSE = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                 imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS) - 2));
  localparam int RD_WAIT  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                 ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int CNT_W    = $clog2(imax(WR_PULSE, RD_WAIT) + 1);

  ctrl_state_t       state;
  logic              accept, capture, tmr_load, expired;
  logic [CNT_W-1:0]  tmr_val;
  logic [LANES-1:0]  be_q;
  logic              in_write, in_access;

  sram_ctrl_fsm #(
    .CNT_W   (CNT_W),
    .WR_PULSE(WR_PULSE),
    .RD_WAIT (RD_WAIT)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .expired  (expired),
    .state    (state),
    .accept   (accept),
    .capture  (capture),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  sram_phase_timer #(
    .CNT_W(CNT_W)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (expired)
  );

  sram_lane_path #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANE_W(LANE_W)
  ) i_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .capture  (capture),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .mem_din  (mem_din),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dout),
    .be_q     (be_q),
    .rdata_q  (rsp_rdata)
  );

  assign in_write  = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
  assign in_access = in_write || (state == ST_RWAIT);

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_WHOLD) || (state == ST_RCAPT);
  assign mem_ce_n  = !in_access;
  assign mem_we_n  = (state != ST_WPULSE);
  assign mem_oe_n  = (state != ST_RWAIT);
  assign mem_drive = in_write;
  assign mem_be_n  = ~(be_q & {LANES{in_access}});

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2,
  parameter int CLK_NS   = 10,
  parameter int T_PWE_NS = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic              mem_drive,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dout
);

  localparam int MIN_LOW = ((T_PWE_NS + CLK_NS - 1) / CLK_NS < 1) ? 1
                           : (T_PWE_NS + CLK_NS - 1) / CLK_NS;

  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    low_cnt <= '0;
    else if (!mem_we_n) begin
      if (low_cnt != 16'hFFFF)     low_cnt <= low_cnt + 16'd1;
    end else                       low_cnt <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_drive && (&mem_be_n)));

  p_rsp_not_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (low_cnt >= 16'(MIN_LOW)));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dout)));

  p_no_drive_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_drive);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !mem_drive);

  p_we_in_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_drive));

  p_we_ends_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_drive));

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .LANES   (DATA_W / LANE_W),
  .CLK_NS  (CLK_NS),
  .T_PWE_NS(T_PWE_NS)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_be_n (mem_be_n),
  .mem_drive(mem_drive),
  .mem_addr (mem_addr),
  .mem_dout (mem_dout)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;

  localparam int CLK_PERIOD = 10;

  function automatic int up_cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  // R3 / R6 cycle counts from the nanosecond limits
  localparam int P_EXP = 4;
  localparam int R_EXP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dout;
  logic [15:0] mem_din;
  logic        mem_drive;

  int n_run = 0, n_fail = 0;
  int m_run = 0, m_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dout(mem_dout),
    .mem_din(mem_din), .mem_drive(mem_drive)
  );

  // ---------------- memory model ----------------
  logic [15:0] mem_arr [0:255];
  int          oe_age, wlow;
  logic        prev_we;
  logic [15:0] pend;

  always_comb begin
    mem_din = 16'hBEEF;
    if (!mem_ce_n && !mem_oe_n && mem_we_n && (oe_age + 1 >= R_EXP)) begin
      mem_din[7:0]  = mem_be_n[0] ? 8'hA5 : mem_arr[mem_addr[7:0]][7:0];
      mem_din[15:8] = mem_be_n[1] ? 8'hA5 : mem_arr[mem_addr[7:0]][15:8];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      oe_age  <= 0;
      wlow    <= 0;
      prev_we <= 1'b1;
      pend    <= '0;
      for (int i = 0; i < 256; i++) mem_arr[i] <= 16'h0;
    end else begin
      oe_age  <= (!mem_ce_n && !mem_oe_n) ? oe_age + 1 : 0;
      prev_we <= mem_we_n;
      if (mem_drive && !mem_oe_n) begin
        m_fail <= m_fail + 1;
        $display("FAIL R7: drive=%b with oe_n=%b, expected no drive", mem_drive, mem_oe_n);
      end
      if (!mem_we_n) begin
        wlow <= wlow + 1;
        pend <= mem_dout;
        if (!mem_drive || mem_ce_n) begin
          m_fail <= m_fail + 1;
          $display("FAIL R8: strobe low with ce_n=%b drive=%b, expected 0/1", mem_ce_n, mem_drive);
        end
      end else begin
        wlow <= 0;
        if (!prev_we) begin
          m_run <= m_run + 1;
          if (wlow < P_EXP || mem_ce_n) begin
            m_fail <= m_fail + 1;
            $display("FAIL R3: pulse %0d cycles ce_n=%b at end, expected >=%0d and 0", wlow, mem_ce_n, P_EXP);
          end
          if (!mem_be_n[0]) mem_arr[mem_addr[7:0]][7:0]  <= pend[7:0];
          if (!mem_be_n[1]) mem_arr[mem_addr[7:0]][15:8] <= pend[15:8];
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  // pins packed as {ready, rsp, ce_n, we_n, oe_n, drive, be_n[1:0]}
  function automatic logic [7:0] pins();
    return {req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_drive, mem_be_n};
  endfunction

  task automatic chk_pins(input string rq, input logic [7:0] exp);
    n_run++;
    if (pins() !== exp) begin
      n_fail++;
      $display("FAIL %s: pins got %b expected %b at %0t", rq, pins(), exp, $time);
    end
  endtask

  task automatic chk_val(input string rq, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", rq, got, exp, $time);
    end
  endtask

  localparam logic [7:0] IDLE_PINS = 8'b1011_1011;

  logic [15:0] shadow [0:255];

  task automatic start(input logic w, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_body(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    chk_pins("R3 setup", {4'b0001, 2'b11, ~be});
    chk_val("R5 addr", mem_addr, a);
    chk_val("R5 data", mem_dout, d);
    for (int i = 0; i < P_EXP; i++) begin
      @(negedge clk);
      chk_pins("R3 pulse", {4'b0000, 2'b11, ~be});
    end
    @(negedge clk);
    chk_pins("R3 hold", {4'b0101, 2'b11, ~be});
    chk_val("R5 addr held", mem_addr, a);
    @(negedge clk);
    chk_pins("R1 idle after write", IDLE_PINS);
    if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
  endtask

  task automatic read_body(input logic [15:0] a, input logic [1:0] be);
    logic [15:0] exp;
    exp = {be[1] ? shadow[a[7:0]][15:8] : 8'h00, be[0] ? shadow[a[7:0]][7:0] : 8'h00};
    chk_val("R6 addr", mem_addr, a);
    for (int i = 0; i < R_EXP; i++) begin
      chk_pins("R6 wait", {4'b0001, 2'b00, ~be});
      @(negedge clk);
    end
    chk_pins("R6 response", 8'b0111_1011);
    chk_val("R6 rdata", rsp_rdata, exp);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    start(1'b1, a, d, be);
    write_body(a, d, be);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] be);
    start(1'b0, a, 16'h0, be);
    read_body(a, be);
    @(negedge clk);
    chk_pins("R1 idle after read", IDLE_PINS);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R9: run still active at %0t, expected completion", $time);
    $display("[TB] %0d tests run, %0d failed", n_run + m_run, n_fail + m_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 16'h0;
    if (up_cyc(40) != P_EXP || up_cyc(55) != R_EXP) begin
      n_fail++;
      $display("FAIL R3: cycle table %0d/%0d expected %0d/%0d", up_cyc(40), up_cyc(55), P_EXP, R_EXP);
    end
    repeat (3) @(negedge clk);
    chk_pins("R1 in reset", IDLE_PINS);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pins("R1 after reset", IDLE_PINS);

    do_write(16'h0005, 16'h1234, 2'b11);   // R3 R4 R5 full word
    do_read (16'h0005, 2'b11);             // R6
    do_write(16'h0005, 16'hABCD, 2'b10);   // R4 high lane only
    do_read (16'h0005, 2'b01);             // R6 low lane, high zeroed
    do_read (16'h0005, 2'b10);             // R6 high lane, low zeroed
    do_read (16'h0005, 2'b11);             // R4 merged word AB34
    do_write(16'hC0F0, 16'h77EE, 2'b01);   // R4 low lane only, upper address bits
    do_read (16'hC0F0, 2'b11);
    do_write(16'h0005, 16'hFFFF, 2'b00);   // R4 no lane: memory unchanged
    do_read (16'h0005, 2'b11);
    do_read (16'h0005, 2'b00);             // R6 no lane: zero result

    // R2 R7: write request held high across the end of a read
    start(1'b0, 16'hC0F0, 16'h0, 2'b11);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0010;
    req_wdata = 16'h5A5A; req_be = 2'b11;
    read_body(16'hC0F0, 2'b11);            // ready stays low while busy
    @(negedge clk);
    chk_pins("R7 idle gap before drive", IDLE_PINS);
    @(negedge clk);
    req_valid = 1'b0;
    write_body(16'h0010, 16'h5A5A, 2'b11); // R2 taken in the idle cycle
    do_read(16'h0010, 2'b11);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run + m_run, n_fail + m_fail);
    $finish;
  end

endmodule